// File: doc/BRIEF.md
# Conditional vector element extractor

This unit takes a wide vector operand, a predicate with one bit per vector byte, an element-size code and a 64-bit fallback scalar. It finds the highest-numbered active element. A mode bit then selects one of two elements: the element that follows it, wrapping to element zero after the final element, or that last active element itself. The chosen element is zero-extended to 64 bits and returned. When no element is active, the result is the low element-width bits of the fallback scalar, with the upper bits cleared.

Operands enter through a valid/ready stream and results leave through another. An operand is taken on any edge where `in_valid` and `in_ready` are both high. With the default registered build, its result is on `out_data` with `out_valid` high one clock later. A result stays on the output, unchanged, until a cycle in which `out_ready` is high. New input is accepted only when the output register is empty or is being drained in that same cycle, so `in_ready` follows `out_ready` combinationally whenever a result is held. Setting `REG_OUT` to 0 removes the register, and results and handshakes then pass straight through.

Top module: `lane_pick_unit`

## Requirements
- R1: The size code `in_size` sets the element width to 8 << code bits: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. The element count is VL divided by that width, and element i occupies vector bits [i*width +: width].
- R2: Element i is active when predicate bit i*(width/8) is set, which is the lowest bit of its byte group. All other predicate bits are ignored.
- R3: With `in_take_last` = 0, the result is the element whose index is one above the last active index. When the last active element is the final element, the result is element 0.
- R4: With `in_take_last` = 1, the result is the last active element itself.
- R5: With no active element, the result is the low width bits of `in_scalar`.
- R6: Every result is zero-extended: bits of `out_data` at and above the element width read 0.
- R7: An operand accepted on an edge (`in_valid` and `in_ready` both high) gives `out_valid` high after that edge, carrying its result.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold and `in_ready` is low.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.
- R10: VL is a power of two from 128 to 2048 bits. The unit behaves as above at both ends of that range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set present |
| in_ready | output | 1 | Unit can take an operand set this cycle |
| in_vec | input | VL | Vector operand |
| in_pred | input | VL/8 | Byte-granular predicate |
| in_size | input | 2 | Element-size code |
| in_take_last | input | 1 | 1: last active element, 0: element after it |
| in_scalar | input | 64 | Fallback scalar |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Zero-extended result |

## Verification
Two things can happen in one cycle: a held result is drained and a new operand set is accepted. For that to work, `in_ready` must follow `out_ready` while a result is waiting. The bench toggles `out_ready` at random while the driver keeps offering operands, so drains and acceptances often land on the same edge. The scoreboard then checks that every result arrives once and in order, and that every stalled output stays constant until it is taken.

// File: rtl/lane_pick_pkg.sv
package lane_pick_pkg;

  localparam int SCALAR_W = 64;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } elem_size_e;

  // Keep the low (8 << code) bits of a scalar and clear the rest.
  function automatic logic [SCALAR_W-1:0] low_bits(input logic [SCALAR_W-1:0] v,
                                                   input logic [1:0] code);
    logic [SCALAR_W-1:0] m;
    unique case (elem_size_e'(code))
      ESZ_8:   m = 64'h0000_0000_0000_00FF;
      ESZ_16:  m = 64'h0000_0000_0000_FFFF;
      ESZ_32:  m = 64'h0000_0000_FFFF_FFFF;
      default: m = 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
    return v & m;
  endfunction

endpackage

// File: rtl/lane_pick_finder.sv
// Highest-set-bit encoder: reports whether any bit is set and the top index.
module lane_pick_finder #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  act,
  output logic          any,
  output logic [IW-1:0] top
);
  always_comb begin
    any = 1'b0;
    top = '0;
    for (int i = 0; i < N; i++) begin
      if (act[i]) begin
        any = 1'b1;
        top = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lane_pick_path.sv
// One element-size variant: active-lane map, last-lane search, lane select.
module lane_pick_path #(
  parameter int VL        = 128,
  parameter int LOG_BYTES = 0,
  localparam int EW = 8 << LOG_BYTES,
  localparam int EB = EW / 8,
  localparam int NE = VL / EW,
  localparam int PW = VL / 8,
  localparam int IW = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic [VL-1:0] vec,
  input  logic [PW-1:0] pred,
  input  logic          take_last,
  output logic          hit,
  output logic [63:0]   elem
);
  logic [NE-1:0] act;
  logic [EW-1:0] lanes [NE];
  logic [IW-1:0] last_idx;
  logic [IW-1:0] pick_idx;

  for (genvar i = 0; i < NE; i++) begin : g_lane
    assign act[i]   = pred[i*EB];
    assign lanes[i] = vec[i*EW +: EW];
  end

  lane_pick_finder #(.N(NE)) u_find (
    .act (act),
    .any (hit),
    .top (last_idx)
  );

  always_comb begin
    if (take_last)                      pick_idx = last_idx;
    else if (last_idx == IW'(NE - 1))   pick_idx = '0;
    else                                pick_idx = last_idx + IW'(1);
  end

  assign elem = 64'(lanes[pick_idx]);
endmodule

// File: rtl/lane_pick_unit.sv
module lane_pick_unit #(
  parameter int VL      = 128,
  parameter int REG_OUT = 1,
  localparam int PW = VL / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [VL-1:0] in_vec,
  input  logic [PW-1:0] in_pred,
  input  logic [1:0]    in_size,
  input  logic          in_take_last,
  input  logic [63:0]   in_scalar,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [63:0]   out_data
);
  import lane_pick_pkg::*;

  logic        hits  [4];
  logic [63:0] elems [4];
  logic [63:0] result;

  for (genvar s = 0; s < 4; s++) begin : g_size
    lane_pick_path #(.VL(VL), .LOG_BYTES(s)) u_path (
      .vec       (in_vec),
      .pred      (in_pred),
      .take_last (in_take_last),
      .hit       (hits[s]),
      .elem      (elems[s])
    );
  end

  always_comb begin
    if (hits[in_size]) result = elems[in_size];
    else               result = low_bits(in_scalar, in_size);
  end

  if (REG_OUT != 0) begin : g_reg
    logic        v_q;
    logic [63:0] d_q;
    logic        take;
    assign in_ready = !v_q || out_ready;
    assign take     = in_valid && in_ready;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else begin
        if (take) begin
          v_q <= 1'b1;
          d_q <= result;
        end else if (out_ready) begin
          v_q <= 1'b0;
        end
      end
    end
    assign out_valid = v_q;
    assign out_data  = d_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = result;
  end
endmodule

// File: rtl/lane_pick_unit_chk.sv
module lane_pick_unit_chk #(
  parameter int REGD = 1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [1:0]  in_size,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data
);
  if (REGD != 0) begin : g_on
    // R7
    accept_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R8
    stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);
    // R6
    zext8_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_size == 2'd0 |=> out_data[63:8] == '0);
    // R6
    zext16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_size == 2'd1 |=> out_data[63:16] == '0);
    // R6
    zext32_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && in_size == 2'd2 |=> out_data[63:32] == '0);
    // R9
    reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
  end
endmodule

bind lane_pick_unit lane_pick_unit_chk #(.REGD(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_size   (in_size),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/lane_pick_harness.sv
module lane_pick_harness #(
  parameter int VL = 128,
  localparam int PW = VL / 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_checks,
  output int   n_fails
);
  logic          in_valid, in_ready, in_take_last, out_valid, out_ready;
  logic [VL-1:0] in_vec;
  logic [PW-1:0] in_pred;
  logic [1:0]    in_size;
  logic [63:0]   in_scalar, out_data;

  logic [63:0] q_exp [$];
  string       q_tag [$];

  lane_pick_unit #(.VL(VL)) u_lane_pick_unit (
    .clk, .rst_n, .in_valid, .in_ready, .in_vec, .in_pred, .in_size,
    .in_take_last, .in_scalar, .out_valid, .out_ready, .out_data
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s VL=%0d actual=%h expected=%h", tag, VL, act, exp);
    end
  endtask

  // Independent model written from the requirements.
  function automatic logic [63:0] model(input logic [VL-1:0] v, input logic [PW-1:0] p,
                                        input logic [1:0] sz, input logic tl,
                                        input logic [63:0] sc);
    int w = 8 << sz;
    int n = VL / w;
    int last = -1;
    int sel;
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) if (p[i*(w/8)]) last = i;
    if (last < 0) begin
      for (int b = 0; b < w; b++) r[b] = sc[b];
      return r;
    end
    sel = tl ? last : ((last + 1 == n) ? 0 : last + 1);
    for (int b = 0; b < w; b++) r[b] = v[sel*w + b];
    return r;
  endfunction

  task automatic send(input logic [VL-1:0] v, input logic [PW-1:0] p, input logic [1:0] sz,
                      input logic tl, input logic [63:0] sc, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_vec = v; in_pred = p; in_size = sz; in_take_last = tl; in_scalar = sc;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    q_exp.push_back(model(v, p, sz, tl, sc));
    q_tag.push_back(tag);
    @(negedge clk);
    check("R7", 64'(out_valid), 64'd1);
    in_valid = 1'b0;
  endtask

  function automatic logic [VL-1:0] rand_vec();
    logic [VL-1:0] v;
    for (int k = 0; k < VL/32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [PW-1:0] rand_pred(input int style);
    logic [PW-1:0] p = '0;
    for (int k = 0; k < PW; k++) begin
      case (style)
        0: p[k] = $urandom % 2;
        1: p[k] = ($urandom % 8) == 0;
        default: p[k] = 1'b0;
      endcase
    end
    if (style >= 2) p[$urandom % PW] = 1'b1;
    return p;
  endfunction

  // Monitor: random back-pressure, in-order compare, hold check.
  initial begin
    logic        prev_stall = 1'b0;
    logic [63:0] prev_data  = '0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      #1;
      if (rst_n) begin
        if (prev_stall) begin
          check("R8", 64'(out_valid), 64'd1);
          check("R8", out_data, prev_data);
          check("R8", 64'(in_ready), 64'(out_ready));
        end
        if (out_valid && out_ready) begin
          if (q_exp.size() == 0) check("R7 unexpected result", out_data, 64'hx);
          else check(q_tag.pop_front(), out_data, q_exp.pop_front());
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
      end
    end
  end

  initial begin
    logic [PW-1:0] p;
    done = 1'b0; n_checks = 0; n_fails = 0;
    in_valid = 1'b0; in_vec = '0; in_pred = '0; in_size = '0; in_take_last = 1'b0; in_scalar = '0;
    @(posedge rst_n);
    @(negedge clk); #1;
    check("R9", 64'(out_valid), 64'd0);
    check("R9", 64'(in_ready), 64'd1);
    for (int s = 0; s < 4; s++) begin
      // R5 R6: no active lane, fallback scalar
      send(rand_vec(), '0, 2'(s), 1'b0, 64'hA5C3_F00D_1234_9876, "R5");
      // R3: only the final element active wraps to element 0
      p = '0; p[PW - (1 << s)] = 1'b1;
      send(rand_vec(), p, 2'(s), 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
      // R4: same predicate, last-active mode
      send(rand_vec(), p, 2'(s), 1'b1, 64'h0, "R4");
      // R2: only non-lowest bits of groups set -> nothing active
      p = '1;
      for (int k = 0; k < PW; k += (1 << s)) p[k] = 1'b0;
      if (s != 0) send(rand_vec(), p, 2'(s), 1'b0, 64'h1122_3344_5566_7788, "R2");
    end
    for (int t = 0; t < 200; t++)
      send(rand_vec(), rand_pred(t % 3), 2'(t % 4), 1'(t / 4 % 2), {$urandom, $urandom}, "R1");
    while (q_exp.size() != 0) @(negedge clk);
    done = 1'b1;
  end
endmodule

// File: tb/lane_pick_unit_bench.sv
module lane_pick_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic done_n, done_w;
  int   c_n, f_n, c_w, f_w;
  int   wd_fail = 0;

  always #5 clk = ~clk;

  // R10: smallest and largest vector lengths
  lane_pick_harness #(.VL(128))  u_narrow (.clk, .rst_n, .done(done_n), .n_checks(c_n), .n_fails(f_n));
  lane_pick_harness #(.VL(2048)) u_wide   (.clk, .rst_n, .done(done_w), .n_checks(c_w), .n_fails(f_w));

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!(done_n && done_w) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!(done_n && done_w)) begin
      wd_fail = 1;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
    end
    if (c_n == 0 || c_w == 0) begin
      wd_fail++;
      $display("FAIL R10 actual=%0d/%0d checks expected=nonzero", c_n, c_w);
    end
    $display("  [TB] %0d tests run, %0d failed", c_n + c_w + 1, f_n + f_w + wd_fail);
    $finish;
  end
endmodule